// File: doc/BRIEF.md
# Flash Block Protection and Lock Controller

This block keeps the write-protection state of every erase block in a small NOR-style flash array. Each block carries a protect bit and a lock bit. Software changes them with two-cycle command sequences: a 60h setup byte, then a confirm byte whose address falls inside the target block. The level of a write-protect input decides whether a locked block can be changed, and its edges force or restore protection on locked blocks.

The program/erase engine presents an address and gets back a single "may modify" bit. The identifier-read path presents an address and gets back the protect and lock bits of that block. Address decoding covers an array of large main blocks plus a group of small parameter blocks. A parameter places that group at the top or the bottom of the map.

Top module: `blk_prot_ctrl`

## Requirements
- R1: After reset every block is protected (protect=1) and unlocked (lock=0).
- R2: A write of 60h arms the sequencer. The next write is the confirm: 01h protects, D0h unprotects, 2Fh locks. The block addressed in the confirm write is the target. Any write outside an armed sequence (01h, D0h or 2Fh included) changes no block.
- R3: Any other confirm byte changes no block and raises seq_err_o for exactly the one cycle after that write. Status logic uses this pulse to set its sequence-error bits (bits 4 and 5).
- R4: With wp_i high, protect and unprotect act on a block whether or not it is locked. Lock sets both lock and protect to 1.
- R5: With wp_i low, lock on an unlocked block sets lock=1 and protect=1 and keeps its previous protect value. A locked block ignores protect, unprotect and lock. An unlocked block obeys protect and unprotect.
- R6: On a falling wp_i edge every locked block becomes protected and keeps its previous protect value. Unlocked blocks do not change.
- R7: On a rising wp_i edge every locked block takes back the protect value it kept (at the falling edge or at a lock under low wp_i). Unlocked blocks do not change.
- R8: pe_ok_o is 1 exactly when the block holding pe_addr_i is unprotected, that is in states (wp, lock, protect) 100, 110 and 000.
- R9: When id_addr_i[1:0] = 2'b10, id_data_o carries protect on bit 0 and lock on bit 1, with bits 15:2 at 0. Any other value of id_addr_i[1:0] gives 0.
- R10: Blocks are numbered upward with address. By default there are 63 main blocks of 32K words and 8 parameter blocks of 4K words, with the parameter blocks at the top of the map (block 63 at 1F8000h, block 64 at 1F9000h). A parameter moves the parameter blocks to the bottom.
- R11: Only reset clears a lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Write-protect level, synchronous to clk_i |
| wr_i | input | 1 | Command write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Word address of the command write |
| wr_data_i | input | 8 | Command byte |
| id_addr_i | input | ADDR_W | Identifier-read address |
| id_data_o | output | 16 | Identifier-read data |
| pe_addr_i | input | ADDR_W | Address the program/erase engine wants to modify |
| pe_ok_o | output | 1 | Addressed block may be programmed or erased |
| seq_err_o | output | 1 | One-cycle pulse after a bad confirm byte |

## Verification
The range check in the decoder assumes every address lies inside the configured map. The stimulus therefore uses only addresses below 200000h. The edge-based properties assume wp_i is already synchronous and holds steady for at least one clock after each change. The bench changes wp_i only through a task that holds the new level for several cycles. Its command writes are single-cycle strobes, so each confirm lands in the cycle after its setup.

// File: rtl/blk_prot_pkg.sv
package blk_prot_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_PROTECT = 8'h01;
  localparam logic [7:0] CMD_UNPROT  = 8'h D0;
  localparam logic [7:0] CMD_LOCK    = 8'h2F;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROT   = 2'd1,
    OP_UNPROT = 2'd2,
    OP_LOCK   = 2'd3
  } prot_op_e;
endpackage

// File: rtl/blk_addr_decode.sv
module blk_addr_decode #(
  parameter int N_MAIN      = 63,
  parameter int N_PARAM     = 8,
  parameter int MAIN_LOG2   = 15,
  parameter int PARAM_LOG2  = 12,
  parameter bit TOP_BOOT    = 1'b1,
  parameter int ADDR_W      = 21,
  parameter int BLK_W       = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BLK_W-1:0]  blk_o
);
  localparam int N_BLK = N_MAIN + N_PARAM;

  if (TOP_BOOT) begin : g_top
    localparam logic [ADDR_W-1:0] P_BASE = ADDR_W'(N_MAIN) << MAIN_LOG2;
    logic [ADDR_W-1:0] off;
    assign off = addr_i - P_BASE;
    always_comb begin
      if (addr_i >= P_BASE) blk_o = BLK_W'(N_MAIN) + BLK_W'(off >> PARAM_LOG2);
      else                  blk_o = BLK_W'(addr_i >> MAIN_LOG2);
    end
  end else begin : g_bot
    localparam logic [ADDR_W-1:0] P_END = ADDR_W'(N_PARAM) << PARAM_LOG2;
    logic [ADDR_W-1:0] off;
    assign off = addr_i - P_END;
    always_comb begin
      if (addr_i < P_END) blk_o = BLK_W'(addr_i >> PARAM_LOG2);
      else                blk_o = BLK_W'(N_PARAM) + BLK_W'(off >> MAIN_LOG2);
    end
  end

  // R10: decoded index stays inside the array for in-map addresses
  always_comb begin
    a_r10_blk_range: assert (int'(blk_o) < N_BLK);
  end
endmodule

// File: rtl/prot_cmd_seq.sv
module prot_cmd_seq
  import blk_prot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output prot_op_e   op_o,
  output logic       seq_err_o
);
  logic armed_q, err_q;

  always_comb begin
    op_o = OP_NONE;
    if (wr_i && armed_q) begin
      unique case (data_i)
        CMD_PROTECT: op_o = OP_PROT;
        CMD_UNPROT:  op_o = OP_UNPROT;
        CMD_LOCK:    op_o = OP_LOCK;
        default:     op_o = OP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= wr_i && armed_q && (op_o == OP_NONE);
      if (wr_i) armed_q <= !armed_q && (data_i == CMD_SETUP);
    end
  end

  assign seq_err_o = err_q;

  a_r3_err_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> $past(armed_q) && $past(wr_i));
  a_r2_confirm_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && armed_q) |=> !armed_q);
endmodule

// File: rtl/blk_prot_cell.sv
module blk_prot_cell
  import blk_prot_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wp_lvl_i,
  input  logic     wp_fall_i,
  input  logic     wp_rise_i,
  input  logic     sel_i,
  input  prot_op_e op_i,
  output logic     prot_o,
  output logic     lock_o
);
  logic prot_q, lock_q, shad_q;
  logic prot_d, lock_d, shad_d;

  always_comb begin
    prot_d = prot_q;
    lock_d = lock_q;
    shad_d = shad_q;
    if (wp_fall_i && lock_q) begin
      shad_d = prot_q;
      prot_d = 1'b1;
    end
    if (wp_rise_i && lock_q) prot_d = shad_q;
    if (sel_i) begin
      unique case (op_i)
        OP_PROT:   if (wp_lvl_i || !lock_q) prot_d = 1'b1;
        OP_UNPROT: if (wp_lvl_i || !lock_q) prot_d = 1'b0;
        OP_LOCK: begin
          if (wp_lvl_i) begin
            lock_d = 1'b1;
            prot_d = 1'b1;
          end else if (!lock_q) begin
            shad_d = prot_d;
            lock_d = 1'b1;
            prot_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= 1'b1;
      lock_q <= 1'b0;
      shad_q <= 1'b1;
    end else begin
      prot_q <= prot_d;
      lock_q <= lock_d;
      shad_q <= shad_d;
    end
  end

  assign prot_o = prot_q;
  assign lock_o = lock_q;

  a_r5_low_locked_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !wp_lvl_i && !wp_fall_i) |-> prot_q);
  a_r11_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  a_r7_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_rise_i && lock_q && !sel_i) |=> (prot_q == $past(shad_q)));
endmodule

// File: rtl/blk_prot_ctrl.sv
module blk_prot_ctrl
  import blk_prot_pkg::*;
#(
  parameter int N_MAIN     = 63,
  parameter int N_PARAM    = 8,
  parameter int MAIN_LOG2  = 15,
  parameter int PARAM_LOG2 = 12,
  parameter bit TOP_BOOT   = 1'b1,
  parameter int ADDR_W     = $clog2(N_MAIN * (1 << MAIN_LOG2) + N_PARAM * (1 << PARAM_LOG2))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] id_addr_i,
  output logic [15:0]       id_data_o,
  input  logic [ADDR_W-1:0] pe_addr_i,
  output logic              pe_ok_o,
  output logic              seq_err_o
);
  localparam int N_BLK = N_MAIN + N_PARAM;
  localparam int BLK_W = $clog2(N_BLK);

  logic [BLK_W-1:0] wr_blk, id_blk, pe_blk;
  logic [N_BLK-1:0] prot_v, lock_v;
  prot_op_e         op;
  logic             wp_q, wp_seen_q, wp_fall, wp_rise;

  blk_addr_decode #(.N_MAIN(N_MAIN), .N_PARAM(N_PARAM), .MAIN_LOG2(MAIN_LOG2),
    .PARAM_LOG2(PARAM_LOG2), .TOP_BOOT(TOP_BOOT), .ADDR_W(ADDR_W), .BLK_W(BLK_W))
    u_dec_wr (.addr_i(wr_addr_i), .blk_o(wr_blk));
  blk_addr_decode #(.N_MAIN(N_MAIN), .N_PARAM(N_PARAM), .MAIN_LOG2(MAIN_LOG2),
    .PARAM_LOG2(PARAM_LOG2), .TOP_BOOT(TOP_BOOT), .ADDR_W(ADDR_W), .BLK_W(BLK_W))
    u_dec_id (.addr_i(id_addr_i), .blk_o(id_blk));
  blk_addr_decode #(.N_MAIN(N_MAIN), .N_PARAM(N_PARAM), .MAIN_LOG2(MAIN_LOG2),
    .PARAM_LOG2(PARAM_LOG2), .TOP_BOOT(TOP_BOOT), .ADDR_W(ADDR_W), .BLK_W(BLK_W))
    u_dec_pe (.addr_i(pe_addr_i), .blk_o(pe_blk));

  prot_cmd_seq u_seq (
    .clk_i, .rst_ni, .wr_i, .data_i(wr_data_i), .op_o(op), .seq_err_o
  );

  // first cycle after reset only samples wp_i, so no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q      <= 1'b0;
      wp_seen_q <= 1'b0;
    end else begin
      wp_q      <= wp_i;
      wp_seen_q <= 1'b1;
    end
  end
  assign wp_fall = wp_seen_q && wp_q && !wp_i;
  assign wp_rise = wp_seen_q && !wp_q && wp_i;

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    blk_prot_cell u_cell (
      .clk_i, .rst_ni,
      .wp_lvl_i (wp_i),
      .wp_fall_i(wp_fall),
      .wp_rise_i(wp_rise),
      .sel_i    ((op != OP_NONE) && (wr_blk == BLK_W'(b))),
      .op_i     (op),
      .prot_o   (prot_v[b]),
      .lock_o   (lock_v[b])
    );
  end

  always_comb begin
    id_data_o = '0;
    if (id_addr_i[1:0] == 2'b10) id_data_o[1:0] = {lock_v[id_blk], prot_v[id_blk]};
  end

  assign pe_ok_o = !prot_v[pe_blk];

  a_r3_err_without_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_err_o && !$past(wp_fall) && !$past(wp_rise)) |-> $stable(prot_v) && $stable(lock_v));
endmodule

// File: tb/blk_prot_ctrl_test.sv
module blk_prot_ctrl_test;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp = 1'b1;
  logic          wr = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] id_addr = '0;
  logic [AW-1:0] pe_addr = '0;
  logic [15:0]   id_data;
  logic          pe_ok, seq_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp_id;
    logic        exp_ok;
    logic        exp_err;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #2 clk = !clk;

  blk_prot_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .wr_i(wr), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .id_addr_i(id_addr), .id_data_o(id_data),
    .pe_addr_i(pe_addr), .pe_ok_o(pe_ok), .seq_err_o(seq_err)
  );

  // monitor: compare one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (id_data !== it.exp_id || pe_ok !== it.exp_ok || seq_err !== it.exp_err) begin
        errors++;
        $display("FAIL %s: id=%h ok=%b err=%b expected id=%h ok=%b err=%b",
                 it.req, id_data, pe_ok, seq_err, it.exp_id, it.exp_ok, it.exp_err);
      end
    end
  end

  task automatic wr_cmd(input logic [AW-1:0] a, input logic [7:0] d);
    wr = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic seq(input logic [AW-1:0] a, input logic [7:0] conf);
    wr_cmd(a, 8'h60);
    wr_cmd(a, conf);
  endtask

  task automatic chk(input logic [AW-1:0] ida, input logic [AW-1:0] pea,
                     input logic [15:0] eid, input logic eok, input logic eerr,
                     input string req);
    item_t it;
    id_addr = ida; pe_addr = pea;
    it.exp_id = eid; it.exp_ok = eok; it.exp_err = eerr; it.req = req;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic set_wp(input logic v);
    wp = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state, main and parameter blocks
    chk(21'h000002, 21'h000000, 16'h0001, 1'b0, 1'b0, "R1 reset block0");
    chk(21'h1FF002, 21'h1FFFFF, 16'h0001, 1'b0, 1'b0, "R1 reset block70");
    // R9 other low address bits read 0
    chk(21'h000001, 21'h000000, 16'h0000, 1'b0, 1'b0, "R9 addr01");
    chk(21'h000003, 21'h000000, 16'h0000, 1'b0, 1'b0, "R9 addr11");
    // R2 unprotect block1 with confirm at end of block
    seq(21'h00FFFF, 8'hD0);
    chk(21'h008002, 21'h008123, 16'h0000, 1'b1, 1'b0, "R2 R8 unprotect block1");
    chk(21'h010002, 21'h010000, 16'h0001, 1'b0, 1'b0, "R10 block2 untouched");
    chk(21'h000002, 21'h000000, 16'h0001, 1'b0, 1'b0, "R10 block0 untouched");
    // R2 lone confirm byte ignored
    wr_cmd(21'h018000, 8'hD0);
    chk(21'h018002, 21'h018000, 16'h0001, 1'b0, 1'b0, "R2 lone confirm ignored");
    // R3 bad confirm
    seq(21'h018000, 8'h55);
    chk(21'h018002, 21'h018000, 16'h0001, 1'b0, 1'b1, "R3 bad confirm pulse");
    chk(21'h018002, 21'h018000, 16'h0001, 1'b0, 1'b0, "R3 pulse one cycle");
    // R4 lock and unprotect with wp high
    seq(21'h008000, 8'h2F);
    chk(21'h008002, 21'h008000, 16'h0003, 1'b0, 1'b0, "R4 lock wp high");
    seq(21'h008000, 8'hD0);
    chk(21'h008002, 21'h008000, 16'h0002, 1'b1, 1'b0, "R4 unprotect locked wp high");
    seq(21'h010000, 8'h2F);
    chk(21'h010002, 21'h010000, 16'h0003, 1'b0, 1'b0, "R4 lock block2");
    seq(21'h020000, 8'hD0);
    chk(21'h020002, 21'h020000, 16'h0000, 1'b1, 1'b0, "R2 unprotect block4");
    // R6 falling edge
    set_wp(1'b0);
    chk(21'h008002, 21'h008000, 16'h0003, 1'b0, 1'b0, "R6 block1 forced");
    chk(21'h010002, 21'h010000, 16'h0003, 1'b0, 1'b0, "R6 block2 forced");
    chk(21'h020002, 21'h020000, 16'h0000, 1'b1, 1'b0, "R6 unlocked unchanged");
    // R5 wp low behaviour
    seq(21'h008000, 8'hD0);
    chk(21'h008002, 21'h008000, 16'h0003, 1'b0, 1'b0, "R5 locked ignores unprotect");
    seq(21'h020000, 8'h2F);
    chk(21'h020002, 21'h020000, 16'h0003, 1'b0, 1'b0, "R5 lock under low wp");
    seq(21'h028000, 8'hD0);
    chk(21'h028002, 21'h028000, 16'h0000, 1'b1, 1'b0, "R5 unlocked unprotect");
    seq(21'h028000, 8'h01);
    chk(21'h028002, 21'h028000, 16'h0001, 1'b0, 1'b0, "R5 unlocked protect");
    seq(21'h028000, 8'hD0);
    chk(21'h028002, 21'h028000, 16'h0000, 1'b1, 1'b0, "R5 unlocked unprotect again");
    // R7 rising edge restores
    set_wp(1'b1);
    chk(21'h008002, 21'h008000, 16'h0002, 1'b1, 1'b0, "R7 block1 restored 0");
    chk(21'h010002, 21'h010000, 16'h0003, 1'b0, 1'b0, "R7 block2 restored 1");
    chk(21'h020002, 21'h020000, 16'h0002, 1'b1, 1'b0, "R7 block4 restored 0");
    chk(21'h028002, 21'h028000, 16'h0000, 1'b1, 1'b0, "R7 unlocked unchanged");
    seq(21'h020000, 8'h01);
    chk(21'h020002, 21'h020000, 16'h0003, 1'b0, 1'b0, "R4 protect locked wp high");
    // R10 parameter block decode
    seq(21'h1F9ABC, 8'hD0);
    chk(21'h1F9002, 21'h1F9FFF, 16'h0000, 1'b1, 1'b0, "R10 param block64");
    chk(21'h1F8002, 21'h1F8000, 16'h0001, 1'b0, 1'b0, "R10 param block63");
    chk(21'h1FA002, 21'h1FA000, 16'h0001, 1'b0, 1'b0, "R10 param block65");
    chk(21'h1F0002, 21'h1F7FFF, 16'h0001, 1'b0, 1'b0, "R10 main block62");
    // R11 locks stay until reset, then clear
    chk(21'h010002, 21'h010000, 16'h0003, 1'b0, 1'b0, "R11 lock held");
    do_reset();
    chk(21'h010002, 21'h010000, 16'h0001, 1'b0, 1'b0, "R11 R1 reset clears lock");
    chk(21'h1F9002, 21'h1F9000, 16'h0001, 1'b0, 1'b0, "R1 reset reprotects");
    @(posedge clk); #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule